// File: doc/BRIEF.md
# Byte-Port Interrupt Summary and Mask

This block gathers eleven level-sensitive interrupt request lines and exposes them to a host through two byte-wide I/O ports that sit at adjacent addresses. The eight lines of the first port carry slot requests, the cascade from the legacy interrupt controller pair, the network controller and the storage controller. The second port carries the three remaining slot requests.

Each port stores a mask that the host writes. A read of a port returns the pending summary for that byte, which is the synchronized request level gated by the inverted mask. One registered output requests service from the CPU whenever any unmasked source is pending.

Request inputs pass through a two-flop synchronizer before they are used. Software is expected to write all ones to both ports before it enables any source, and that is also the reset state. Software services set summary bits from the lowest index upward.

Top module: `irq_summary_port`

## Requirements
- R1: After reset both masks disable every source, `cpu_irq` is 0, and reads of both ports return 0 even while every request line is high.
- R2: Request line `req_in[i]` for i in 0..7 appears at bit i of port 0x26. For i in 8..10 it appears at bit i-8 of port 0x27. The bit roles are: 0x26 bit0 slot0 A, bit1 slot1 A, bit2 slot0 B, bit3 slot1 B, bit4 slot0 C, bit5 legacy cascade, bit6 network, bit7 storage. On 0x27 they are bit0 slot1 C, bit1 slot0 D, bit2 slot1 D.
- R3: A mask bit of 1 disables its source and a mask bit of 0 enables it. A summary bit reads 1 only when its synchronized line is high and its mask bit is 0.
- R4: Bits 7..3 of port 0x27 always read 0, and writes to those bits have no effect.
- R5: Sources are level-sensitive. A summary bit stays 1 while its line is high, even across a host write to the port, and it returns to 0 once the line falls.
- R6: `io_rdata` is registered. It holds the addressed port's summary in the cycle after a clock edge that samples `io_rd` high. It reads 0 for any address other than 0x26 and 0x27, and it reads 0 after any edge that samples `io_rd` low.
- R7: `cpu_irq` is the registered OR of all unmasked pending bits. It rises on the third clock edge after a request line rises, which covers two synchronizer stages and the output register. It follows a mask write one edge after the edge that captures the write.
- R8: A write takes effect on the edge that samples `io_wr` high. A write to any address other than 0x26 and 0x27 leaves both masks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 8 | Byte I/O address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data (mask value) |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Registered read data (pending summary) |
| req_in | input | 11 | Active-high request lines, index order as in R2 |
| cpu_irq | output | 1 | Combined interrupt request to the CPU |

## Verification
The bench drives every request line high through reset and checks that nothing leaks out. A design with the wrong reset mask would assert `cpu_irq` or return nonzero summaries at once. The bench writes ones into the reserved high bits of port 0x27 and then reads that port. It also rewrites an unchanged mask while lines are held high, which catches designs that store reserved bits or treat writes as an acknowledge that clears pending bits. It measures the exact edge on which `cpu_irq` rises after a request and after a masking write, so a missing or extra synchronizer stage shows up as an off-by-one. It also exercises bit 5 and bit 10 to catch a wrong bit mapping.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;
    localparam int PORT_W = 8;

    typedef struct packed {
        logic [PORT_W-1:0] mask_lo;
        logic [PORT_W-1:0] mask_hi;
        logic [PORT_W-1:0] rdata;
    } port_state_t;
endpackage

// File: rtl/irqsum_sync.sv
module irqsum_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stable;
endmodule

// File: rtl/irqsum_regs.sv
module irqsum_regs
    import irqsum_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h26,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h27,
    parameter int                NUM_SRC = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [NUM_SRC-1:0] level,
    output logic [PORT_W-1:0] rdata,
    output logic [NUM_SRC-1:0] pending,
    output logic [PORT_W-1:0] mask_lo,
    output logic [PORT_W-1:0] mask_hi
);
    localparam int                HI_USED = NUM_SRC - PORT_W;
    localparam logic [PORT_W-1:0] HI_KEEP = PORT_W'((1 << HI_USED) - 1);

    port_state_t st_d, st_q;
    logic [NUM_SRC-1:0] mask_all;
    logic [PORT_W-1:0]  sum_lo, sum_hi;

    assign mask_all = {st_q.mask_hi[HI_USED-1:0], st_q.mask_lo};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
        assign pending[i] = level[i] & ~mask_all[i];
    end

    assign sum_lo = pending[PORT_W-1:0];
    assign sum_hi = PORT_W'(pending[NUM_SRC-1:PORT_W]);

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (wr_en) begin
            if (addr == LO_ADDR)      st_d.mask_lo = wdata;
            else if (addr == HI_ADDR) st_d.mask_hi = wdata & HI_KEEP;
        end
        if (rd_en) begin
            if (addr == LO_ADDR)      st_d.rdata = sum_lo;
            else if (addr == HI_ADDR) st_d.rdata = sum_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask_lo <= '1;
            st_q.mask_hi <= HI_KEEP;
            st_q.rdata   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata   = st_q.rdata;
    assign mask_lo = st_q.mask_lo;
    assign mask_hi = st_q.mask_hi;
endmodule

// File: rtl/irqsum_req.sv
module irqsum_req #(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pending,
    output logic               irq
);
    typedef struct packed {
        logic irq;
    } req_t;

    req_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.irq = |pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq = r_q.irq;
endmodule

// File: rtl/irq_summary_port.sv
module irq_summary_port #(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  LO_ADDR = 8'h26,
    parameter logic [7:0]  HI_ADDR = 8'h27,
    parameter int          NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic [7:0]         io_wdata,
    input  logic               io_rd,
    output logic [7:0]         io_rdata,
    input  logic [NUM_SRC-1:0] req_in,
    output logic               cpu_irq
);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

    logic [NUM_SRC-1:0] level;
    logic [NUM_SRC-1:0] pending;
    logic [7:0]         mask_lo;
    logic [7:0]         mask_hi;

    irqsum_sync #(.W(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (req_in),
        .sync_out (level)
    );

    irqsum_regs #(
        .ADDR_W  (ADDR_W),
        .LO_ADDR (LO_A),
        .HI_ADDR (HI_A),
        .NUM_SRC (NUM_SRC)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (io_addr),
        .wr_en   (io_wr),
        .wdata   (io_wdata),
        .rd_en   (io_rd),
        .level   (level),
        .rdata   (io_rdata),
        .pending (pending),
        .mask_lo (mask_lo),
        .mask_hi (mask_hi)
    );

    irqsum_req #(.NUM_SRC(NUM_SRC)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq     (cpu_irq)
    );
endmodule

// File: rtl/irqsum_checker.sv
module irqsum_checker #(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  LO_ADDR = 8'h26,
    parameter logic [7:0]  HI_ADDR = 8'h27,
    parameter int          HI_USED = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_rdata,
    input logic              cpu_irq,
    input logic [7:0]        mask_lo,
    input logic [7:0]        mask_hi
);
    logic is_lo, is_hi;
    assign is_lo = (io_addr == ADDR_W'(LO_ADDR));
    assign is_hi = (io_addr == ADDR_W'(HI_ADDR));

    assert_all_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((&mask_lo) && (&mask_hi[HI_USED-1:0])) |=> !cpu_irq);

    assert_rsvd_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && is_hi) |=> (io_rdata[7:HI_USED] == '0));

    assert_unmapped_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !is_lo && !is_hi) |=> (io_rdata == 8'h00));

    assert_idle_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> (io_rdata == 8'h00));

    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !is_lo && !is_hi) |=> ($stable(mask_lo) && $stable(mask_hi)));
endmodule

bind irq_summary_port irqsum_checker #(
    .ADDR_W  (ADDR_W),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR),
    .HI_USED (NUM_SRC - 8)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_rdata (io_rdata),
    .cpu_irq  (cpu_irq),
    .mask_lo  (mask_lo),
    .mask_hi  (mask_hi)
);

// File: tb/tb_irq_summary_port.sv
module tb_irq_summary_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [10:0] req_in = '1;
    logic        cpu_irq;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_lo = 8'hFF;
    logic [7:0] m_hi = 8'hFF;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       mon_cap;
    logic [7:0] mon_e;
    string      mon_t;

    always #10 clk = ~clk;

    irq_summary_port dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rd(io_rd), .io_rdata(io_rdata),
        .req_in(req_in), .cpu_irq(cpu_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] a);
        if (a == 8'h26) return req_in[7:0] & ~m_lo;
        if (a == 8'h27) return {5'b0, req_in[10:8] & ~m_hi[2:0]};
        return 8'h00;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        if (a == 8'h26) m_lo = d;
        if (a == 8'h27) m_hi = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(model(a));
        tag_q.push_back(tag);
        @(negedge clk);
        io_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Scoreboard monitor: compares each read result one edge after the strobe
    always @(posedge clk) begin
        mon_cap = io_rd;
        #2;
        if (mon_cap && exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            chk(io_rdata == mon_e, mon_t, io_rdata, mon_e);
        end
    end

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1: all lines high but everything masked from reset
        chk(cpu_irq == 1'b0, "R1 irq after reset", cpu_irq, 0);
        rd(8'h26, "R1 low port masked");
        rd(8'h27, "R1 high port masked");

        // R3 / R7: unmask low port, irq follows one edge after capture
        wr(8'h26, 8'h00);
        chk(cpu_irq == 1'b0, "R7 irq before mask edge+1", cpu_irq, 0);
        @(posedge clk); #2;
        chk(cpu_irq == 1'b1, "R7 irq after unmask", cpu_irq, 1);
        rd(8'h26, "R3 low port unmasked");

        // R2: pattern with cascade bit5 set
        @(negedge clk); req_in[7:0] = 8'hA5;
        settle();
        rd(8'h26, "R2 low pattern 0xA5");

        // R2 / R4: high port mapping and reserved bits
        req_in[10:8] = 3'b101;
        wr(8'h27, 8'h00);
        settle();
        rd(8'h27, "R2 high pattern");
        wr(8'h27, 8'hF8);
        m_hi = 8'h00;
        rd(8'h27, "R4 reserved write ignored");

        // R3: partial mask
        wr(8'h26, 8'h0F);
        rd(8'h26, "R3 partial mask");

        // R5: rewrite same mask, pending stays; then line drops
        wr(8'h26, 8'h0F);
        rd(8'h26, "R5 write does not clear");
        @(negedge clk); req_in[7:0] = 8'h20;
        settle();
        rd(8'h26, "R5 level follows line");

        // R6 / R8: unmapped address read and write
        rd(8'h25, "R6 unmapped read");
        wr(8'h28, 8'hFF);
        rd(8'h26, "R8 unmapped write ignored");
        @(negedge clk);
        chk(io_rdata == 8'h00, "R6 idle rdata", io_rdata, 0);

        // R7: exact rise timing of cpu_irq
        wr(8'h26, 8'hFF);
        wr(8'h27, 8'hFF);
        @(negedge clk); req_in = '0;
        settle();
        chk(cpu_irq == 1'b0, "R3 all masked no irq", cpu_irq, 0);
        wr(8'h26, 8'hFE);
        settle();
        @(negedge clk); req_in[0] = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        chk(cpu_irq == 1'b0, "R7 irq not before third edge", cpu_irq, 0);
        @(posedge clk); #2;
        chk(cpu_irq == 1'b1, "R7 irq on third edge", cpu_irq, 1);
        wr(8'h26, 8'hFF);
        chk(cpu_irq == 1'b1, "R7 irq held at capture edge", cpu_irq, 1);
        @(posedge clk); #2;
        chk(cpu_irq == 1'b0, "R7 irq drops after mask", cpu_irq, 0);

        // R2: top source (bit10) lands on high port bit2
        @(negedge clk); req_in = 11'h400;
        wr(8'h27, 8'h03);
        settle();
        rd(8'h27, "R2 bit10 on high bit2");
        chk(cpu_irq == 1'b1, "R7 irq from high port", cpu_irq, 1);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule